// File: doc/BRIEF.md
# Per-Thread Load Queue with Cache Issue Gating

This block tracks the in-flight loads of one thread in a circular queue. Each load takes an entry in program order and is tagged with a sequence number and the index of the store-queue position it follows. When a load is ready to go to memory, the issue side names its slot together with the address, access size and an uncached flag. The queue then decides whether the request may reach the data cache. An uncached access that is not the oldest load, or is not yet at commit, is held back, sent for rescheduling and flagged as a machine-check style fault. A request that the cache refuses marks this thread as needing a retry, and records the oldest such refused load for the pipeline to handle.

Entries are released in bulk when commit reports a sequence number: every load at the front of the queue that is older than it leaves in the same cycle. A squash removes younger loads from the tail end, one slot per clock, until the youngest remaining load is no younger than the squash point. One physical slot is always kept empty, so the queue is full at one entry below its physical size.

Allocation uses a valid/ready handshake: `alloc_ready` is low while the queue is full or a squash is running, and an offered entry simply waits. The cache request also uses valid/ready, but a refused request is not held. `mem_req_valid` follows the issue input in the same cycle, and a refusal is a final outcome that the retry flag and the blocked record report. Control and status pins are plain levels or pulses.

Top module: `load_queue`

## Requirements
- R1: After reset the queue is empty (`lq_count` 0, `lq_full` 0, `alloc_ready` 1, `alloc_idx` 0), no squash is running, and `retry_pend`, `blk_valid` and `blk_handled` are 0.
- R2: When `alloc_valid` and `alloc_ready` are both high, the entry is written at slot `alloc_idx`. The tail advances by one, wrapping from SLOTS-1 to 0, and `lq_count` rises by one after the edge.
- R3: `lq_full` is high exactly when `lq_count` is at least SLOTS-1. `alloc_ready` is low whenever `lq_full` or `squash_busy` is high, so occupancy never exceeds SLOTS-1.
- R4: When `commit_valid` is high and no squash is running, every load in the unbroken run from the head whose sequence number is below `commit_seq` is freed at the next edge. The head moves past all of them.
- R5: An issue of an occupied slot that is cacheable, or that is uncached but is the head slot with `issue_at_commit` high, raises `mem_req_valid` in the same cycle. It carries the issue address and size, together with the slot's stored sequence number and store-queue index.
- R6: An issue of an occupied slot with `issue_uncached` high is gated when the slot is not the head or `issue_at_commit` is low. In that case `mem_req_valid` stays low, and `resched_o` and `fault_o` pulse high in the same cycle.
- R7: A request with `mem_req_valid` high and `mem_req_ready` low sets `retry_pend` at the next edge. A request that is accepted clears it.
- R8: On a refused request the load's sequence number is stored in `blk_seq`, `blk_valid` is set and `blk_handled` is cleared. If a recorded load with a smaller sequence number is already present, the record stays unchanged.
- R9: `blk_ack` sets `blk_handled` and `blk_clear` clears `blk_valid`, each at the next edge. A new record in the same cycle takes priority over both.
- R10: `squash_valid` while idle starts a squash at the next edge. Each cycle of `squash_busy` frees the youngest slot if its sequence number is above `squash_seq`. The first cycle that frees nothing, or finds the queue empty, ends the squash.
- R11: An issue of an unoccupied slot, or any issue while `squash_busy` is high, gives no request, reschedule or fault. `commit_valid` and `squash_valid` are ignored while `squash_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | New load offered for allocation |
| alloc_ready | output | 1 | Queue can take a new load |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_idx | input | SQI_W | Store-queue index of the new load |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| commit_valid | input | 1 | Commit point reported |
| commit_seq | input | SEQ_W | Loads below this number are freed |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Loads above this number are removed |
| squash_busy | output | 1 | Squash walk in progress |
| issue_valid | input | 1 | Load issue request |
| issue_idx | input | IDX_W | Slot of the issuing load |
| issue_addr | input | ADDR_W | Access address |
| issue_size | input | SIZE_W | Access size |
| issue_uncached | input | 1 | Access bypasses the cache |
| issue_at_commit | input | 1 | Load is ready to commit |
| mem_req_valid | output | 1 | Request to the data cache |
| mem_req_ready | input | 1 | Cache takes the request |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_size | output | SIZE_W | Request size |
| mem_req_seq | output | SEQ_W | Request sequence number |
| mem_req_sq_idx | output | SQI_W | Request store-queue index |
| resched_o | output | 1 | Load must be issued again later |
| fault_o | output | 1 | Machine-check style fault for the gated load |
| retry_pend | output | 1 | Thread waits for a cache retry |
| blk_valid | output | 1 | A cache-blocked load is recorded |
| blk_seq | output | SEQ_W | Sequence number of the recorded load |
| blk_handled | output | 1 | Recorded load has been acknowledged |
| blk_ack | input | 1 | Marks the record handled |
| blk_clear | input | 1 | Drops the record |
| lq_count | output | CNT_W | Occupied entries |
| lq_full | output | 1 | Occupancy at SLOTS-1 |

## Verification
The properties assume that sequence numbers rise strictly in allocation order and never wrap within a run, so a plain unsigned compare gives age. They also assume that `mem_req_ready` is only meaningful while a request is offered. The stimulus allocates numbers 10, 20, 30 and so on, well inside the sequence width. It issues to both occupied and free slots, and it drives commit and squash points that fall between, below and above the stored numbers. That includes a squash point above every entry, so a squash frees nothing. The refusal order is chosen so that a younger refused load is kept out of the record and an older one replaces it.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef enum logic [1:0] {
    ISS_NONE    = 2'd0,
    ISS_SEND    = 2'd1,
    ISS_RESCHED = 2'd2
  } iss_kind_e;
endpackage

// File: rtl/lq_slots.sv
module lq_slots #(
  parameter int SLOTS = 8,
  parameter int SEQ_W = 16,
  parameter int SQI_W = 4,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [SEQ_W-1:0]            wr_seq,
  input  logic [SQI_W-1:0]            wr_sqi,
  input  logic [SLOTS-1:0]            clr_mask,
  output logic [SLOTS-1:0]            vld,
  output logic [SLOTS-1:0][SEQ_W-1:0] seq_arr,
  output logic [SLOTS-1:0][SQI_W-1:0] sqi_arr
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[i] <= 1'b0;
      end else if (hit) begin
        vld[i] <= 1'b1;
      end else if (clr_mask[i]) begin
        vld[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        seq_arr[i] <= wr_seq;
        sqi_arr[i] <= wr_sqi;
      end
    end
  end
endmodule

// File: rtl/lq_commit_scan.sv
module lq_commit_scan #(
  parameter int SLOTS = 8,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                        commit_en,
  input  logic [SEQ_W-1:0]            commit_seq,
  input  logic [IDX_W-1:0]            head,
  input  logic [CNT_W-1:0]            count,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq_arr,
  output logic [SLOTS-1:0]            free_mask,
  output logic [CNT_W-1:0]            n_free
);
  int               pos;
  logic [IDX_W-1:0] slot;
  logic             run;

  // Walk from the head in age order; stop at the first load not older.
  always_comb begin
    free_mask = '0;
    n_free    = '0;
    run       = commit_en;
    pos       = 0;
    slot      = '0;
    for (int k = 0; k < SLOTS; k++) begin
      pos = int'(head) + k;
      if (pos >= SLOTS) pos = pos - SLOTS;
      slot = IDX_W'(pos);
      run  = run && (k < int'(count)) && (seq_arr[slot] < commit_seq);
      if (run) begin
        free_mask[slot] = 1'b1;
        n_free = n_free + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lq_issue_gate.sv
module lq_issue_gate #(
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                issue_valid,
  input  logic [IDX_W-1:0]    issue_idx,
  input  logic                issue_uncached,
  input  logic                issue_at_commit,
  input  logic                busy,
  input  logic [SLOTS-1:0]    vld,
  input  logic [IDX_W-1:0]    head,
  output lq_pkg::iss_kind_e   kind
);
  logic live;
  logic unc_blocked;

  assign live        = issue_valid && !busy && vld[issue_idx];
  assign unc_blocked = issue_uncached && ((issue_idx != head) || !issue_at_commit);

  always_comb begin
    if (!live)            kind = lq_pkg::ISS_NONE;
    else if (unc_blocked) kind = lq_pkg::ISS_RESCHED;
    else                  kind = lq_pkg::ISS_SEND;
  end
endmodule

// File: rtl/lq_block_track.sv
module lq_block_track #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refuse,
  input  logic             accept,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic             blk_ack,
  input  logic             blk_clear,
  output logic             retry_pend,
  output logic             blk_valid,
  output logic [SEQ_W-1:0] blk_seq,
  output logic             blk_handled
);
  logic keep_old;
  assign keep_old = blk_valid && (blk_seq < req_seq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_pend <= 1'b0;
    end else if (refuse) begin
      retry_pend <= 1'b1;
    end else if (accept) begin
      retry_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_valid   <= 1'b0;
      blk_seq     <= '0;
      blk_handled <= 1'b0;
    end else if (refuse && !keep_old) begin
      blk_valid   <= 1'b1;
      blk_seq     <= req_seq;
      blk_handled <= 1'b0;
    end else begin
      if (blk_clear) blk_valid   <= 1'b0;
      if (blk_ack)   blk_handled <= 1'b1;
    end
  end
endmodule

// File: rtl/load_queue.sv
module load_queue #(
  parameter int SLOTS  = 8,
  parameter int SEQ_W  = 16,
  parameter int SQI_W  = 4,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [SQI_W-1:0]  alloc_sq_idx,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              squash_busy,
  input  logic              issue_valid,
  input  logic [IDX_W-1:0]  issue_idx,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [SIZE_W-1:0] issue_size,
  input  logic              issue_uncached,
  input  logic              issue_at_commit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [SIZE_W-1:0] mem_req_size,
  output logic [SEQ_W-1:0]  mem_req_seq,
  output logic [SQI_W-1:0]  mem_req_sq_idx,
  output logic              resched_o,
  output logic              fault_o,
  output logic              retry_pend,
  output logic              blk_valid,
  output logic [SEQ_W-1:0]  blk_seq,
  output logic              blk_handled,
  input  logic              blk_ack,
  input  logic              blk_clear,
  output logic [CNT_W-1:0]  lq_count,
  output logic              lq_full
);
  function automatic logic [IDX_W-1:0] step_up(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(SLOTS - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] step_down(input logic [IDX_W-1:0] p);
    return (p == '0) ? IDX_W'(SLOTS - 1) : p - IDX_W'(1);
  endfunction

  logic [IDX_W-1:0]            head_q, tail_q, last_idx;
  logic [CNT_W-1:0]            cnt_q, n_free;
  logic                        busy_q;
  logic [SEQ_W-1:0]            sq_seq_q;
  logic [SLOTS-1:0]            vld, free_mask, pop_mask, clr_mask;
  logic [SLOTS-1:0][SEQ_W-1:0] seq_arr;
  logic [SLOTS-1:0][SQI_W-1:0] sqi_arr;
  logic                        alloc_fire, commit_en, pop;
  logic                        refuse, accept;
  lq_pkg::iss_kind_e           kind;
  int                          head_sum;

  // Occupancy and handshake
  assign lq_full     = cnt_q >= CNT_W'(SLOTS - 1);
  assign alloc_ready = !lq_full && !busy_q;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_q;
  assign lq_count    = cnt_q;
  assign squash_busy = busy_q;

  // Squash walk: youngest slot sits just below the tail
  assign last_idx  = step_down(tail_q);
  assign pop       = busy_q && (cnt_q != '0) && (seq_arr[last_idx] > sq_seq_q);
  assign pop_mask  = pop ? (SLOTS'(1) << last_idx) : '0;
  assign commit_en = commit_valid && !busy_q;
  assign clr_mask  = free_mask | pop_mask;

  lq_slots #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .SQI_W(SQI_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (alloc_fire),
    .wr_idx   (tail_q),
    .wr_seq   (alloc_seq),
    .wr_sqi   (alloc_sq_idx),
    .clr_mask (clr_mask),
    .vld      (vld),
    .seq_arr  (seq_arr),
    .sqi_arr  (sqi_arr)
  );

  lq_commit_scan #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_scan (
    .commit_en  (commit_en),
    .commit_seq (commit_seq),
    .head       (head_q),
    .count      (cnt_q),
    .seq_arr    (seq_arr),
    .free_mask  (free_mask),
    .n_free     (n_free)
  );

  lq_issue_gate #(.SLOTS(SLOTS)) u_gate (
    .issue_valid     (issue_valid),
    .issue_idx       (issue_idx),
    .issue_uncached  (issue_uncached),
    .issue_at_commit (issue_at_commit),
    .busy            (busy_q),
    .vld             (vld),
    .head            (head_q),
    .kind            (kind)
  );

  assign mem_req_valid  = (kind == lq_pkg::ISS_SEND);
  assign resched_o      = (kind == lq_pkg::ISS_RESCHED);
  assign fault_o        = (kind == lq_pkg::ISS_RESCHED);
  assign mem_req_addr   = issue_addr;
  assign mem_req_size   = issue_size;
  assign mem_req_seq    = seq_arr[issue_idx];
  assign mem_req_sq_idx = sqi_arr[issue_idx];
  assign refuse         = mem_req_valid && !mem_req_ready;
  assign accept         = mem_req_valid && mem_req_ready;

  lq_block_track #(.SEQ_W(SEQ_W)) u_block (
    .clk         (clk),
    .rst_n       (rst_n),
    .refuse      (refuse),
    .accept      (accept),
    .req_seq     (mem_req_seq),
    .blk_ack     (blk_ack),
    .blk_clear   (blk_clear),
    .retry_pend  (retry_pend),
    .blk_valid   (blk_valid),
    .blk_seq     (blk_seq),
    .blk_handled (blk_handled)
  );

  always_comb begin
    head_sum = int'(head_q) + int'(n_free);
    if (head_sum >= SLOTS) head_sum = head_sum - SLOTS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      sq_seq_q <= '0;
    end else begin
      head_q <= IDX_W'(head_sum);
      if (alloc_fire)  tail_q <= step_up(tail_q);
      else if (pop)    tail_q <= last_idx;
      cnt_q <= cnt_q + CNT_W'(alloc_fire) - n_free - CNT_W'(pop);
      if (!busy_q && squash_valid) begin
        busy_q   <= 1'b1;
        sq_seq_q <= squash_seq;
      end else if (busy_q && !pop) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lq_checker.sv
module lq_checker #(
  parameter int SLOTS = 8,
  parameter int SEQ_W = 16,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             commit_valid,
  input logic             squash_busy,
  input logic [CNT_W-1:0] lq_count,
  input logic             lq_full,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [SEQ_W-1:0] mem_req_seq,
  input logic             resched_o,
  input logic             retry_pend,
  input logic             blk_valid,
  input logic [SEQ_W-1:0] blk_seq,
  input logic             blk_handled,
  input logic             blk_ack
);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lq_count <= CNT_W'(SLOTS - 1));

  assert_full_blocks_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lq_full |-> !alloc_ready);

  assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !commit_valid) |=> (lq_count == $past(lq_count) + CNT_W'(1)));

  assert_gated_no_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resched_o |-> !mem_req_valid);

  assert_refusal_sets_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> retry_pend);

  assert_first_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !blk_valid) |=>
      (blk_valid && !blk_handled && blk_seq == $past(mem_req_seq)));

  assert_ack_marks_handled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ack && !(mem_req_valid && !mem_req_ready)) |=> blk_handled);

  assert_squash_blocks_alloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    squash_busy |-> !alloc_ready);

  assert_squash_shrinks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    squash_busy |=> (lq_count <= $past(lq_count)));
endmodule

bind load_queue lq_checker #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) i_lq_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_valid   (alloc_valid),
  .alloc_ready   (alloc_ready),
  .commit_valid  (commit_valid),
  .squash_busy   (squash_busy),
  .lq_count      (lq_count),
  .lq_full       (lq_full),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_seq   (mem_req_seq),
  .resched_o     (resched_o),
  .retry_pend    (retry_pend),
  .blk_valid     (blk_valid),
  .blk_seq       (blk_seq),
  .blk_handled   (blk_handled),
  .blk_ack       (blk_ack)
);

// File: tb/test_load_queue.sv
module test_load_queue;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS  = 8;
  localparam int SEQ_W  = 16;
  localparam int SQI_W  = 4;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 4;
  localparam int IDX_W  = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid, alloc_ready;
  logic [SEQ_W-1:0] alloc_seq;
  logic [SQI_W-1:0] alloc_sq_idx;
  logic [IDX_W-1:0] alloc_idx;
  logic commit_valid, squash_valid, squash_busy;
  logic [SEQ_W-1:0] commit_seq, squash_seq;
  logic issue_valid, issue_uncached, issue_at_commit;
  logic [IDX_W-1:0] issue_idx;
  logic [ADDR_W-1:0] issue_addr;
  logic [SIZE_W-1:0] issue_size;
  logic mem_req_valid, mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [SIZE_W-1:0] mem_req_size;
  logic [SEQ_W-1:0] mem_req_seq;
  logic [SQI_W-1:0] mem_req_sq_idx;
  logic resched_o, fault_o, retry_pend;
  logic blk_valid, blk_handled, blk_ack, blk_clear;
  logic [SEQ_W-1:0] blk_seq;
  logic [CNT_W-1:0] lq_count;
  logic lq_full;

  load_queue #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .SQI_W(SQI_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W))
  i_load_queue (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // Behavioural reference: loads in age order, head slot as an integer
  int m_seq[$];
  int m_sqi[$];
  int m_head = 0;
  bit m_busy = 0;
  int m_sqs = 0;
  bit m_retry = 0, m_bv = 0, m_bh = 0;
  int m_bseq = 0;

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_seq = '0; alloc_sq_idx = '0;
    commit_valid = 0; commit_seq = '0;
    squash_valid = 0; squash_seq = '0;
    issue_valid = 0; issue_idx = '0; issue_addr = '0; issue_size = '0;
    issue_uncached = 0; issue_at_commit = 0;
    mem_req_ready = 1; blk_ack = 0; blk_clear = 0;
  endtask

  // Compare every output with the reference, then advance one clock.
  task automatic step();
    int sz, aidx, k, iseq, isqi;
    bit full, ar, live, bad, mreq, rs, keep;
    #1;
    sz   = m_seq.size();
    full = sz >= SLOTS - 1;
    ar   = !full && !m_busy;
    aidx = (m_head + sz) % SLOTS;
    k    = (int'(issue_idx) - m_head + SLOTS) % SLOTS;
    live = issue_valid && !m_busy && (k < sz);
    bad  = issue_uncached && !(k == 0 && issue_at_commit);
    mreq = live && !bad;
    rs   = live && bad;
    iseq = live ? m_seq[k] : 0;
    isqi = live ? m_sqi[k] : 0;

    chk("R3", alloc_ready, ar, "alloc_ready");
    chk("R3", lq_full, full, "lq_full");
    chk("R2 R4 R10", lq_count, sz, "lq_count");
    chk("R2", alloc_idx, aidx, "alloc_idx");
    chk("R10", squash_busy, m_busy, "squash_busy");
    chk("R5 R11", mem_req_valid, mreq, "mem_req_valid");
    if (mreq) begin
      chk("R5", mem_req_seq, iseq, "mem_req_seq");
      chk("R5", mem_req_sq_idx, isqi, "mem_req_sq_idx");
      chk("R5", int'(mem_req_addr), int'(issue_addr), "mem_req_addr");
      chk("R5", mem_req_size, issue_size, "mem_req_size");
    end
    chk("R6 R11", resched_o, rs, "resched_o");
    chk("R6 R11", fault_o, rs, "fault_o");
    chk("R7", retry_pend, m_retry, "retry_pend");
    chk("R8 R9", blk_valid, m_bv, "blk_valid");
    if (m_bv) chk("R8", blk_seq, m_bseq, "blk_seq");
    chk("R9", blk_handled, m_bh, "blk_handled");

    // next state
    if (m_busy) begin
      if (m_seq.size() > 0 && m_seq[$] > m_sqs) begin
        void'(m_seq.pop_back()); void'(m_sqi.pop_back());
      end else m_busy = 0;
    end else begin
      if (commit_valid) begin
        while (m_seq.size() > 0 && m_seq[0] < int'(commit_seq)) begin
          void'(m_seq.pop_front()); void'(m_sqi.pop_front());
          m_head = (m_head + 1) % SLOTS;
        end
      end
      if (squash_valid) begin m_busy = 1; m_sqs = squash_seq; end
    end
    if (alloc_valid && ar) begin
      m_seq.push_back(int'(alloc_seq)); m_sqi.push_back(int'(alloc_sq_idx));
    end
    if (mreq && !mem_req_ready) m_retry = 1;
    else if (mreq) m_retry = 0;
    keep = m_bv && (m_bseq < iseq);
    if (mreq && !mem_req_ready && !keep) begin
      m_bv = 1; m_bseq = iseq; m_bh = 0;
    end else begin
      if (blk_clear) m_bv = 0;
      if (blk_ack) m_bh = 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_issue(int idx, bit unc, bit atc, bit rdy);
    issue_valid = 1; issue_idx = IDX_W'(idx); issue_uncached = unc;
    issue_at_commit = atc; mem_req_ready = rdy;
    issue_addr = ADDR_W'(32'h1000 + idx * 8); issue_size = SIZE_W'(4);
    step();
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", lq_count, 0, "count after reset");
    chk("R1", alloc_ready, 1, "alloc_ready after reset");
    chk("R1", blk_valid, 0, "blk_valid after reset");
    chk("R1", retry_pend, 0, "retry_pend after reset");
    step();

    // R2 R3: fill to SLOTS-1, then offer one more
    for (int i = 1; i <= SLOTS; i++) begin
      alloc_valid = 1; alloc_seq = SEQ_W'(i * 10); alloc_sq_idx = SQI_W'(i);
      step();
    end
    idle();
    chk("R3", lq_count, SLOTS - 1, "occupancy capped");
    chk("R3", lq_full, 1, "full flag");

    // R5 send, R7 R8 refusal records
    do_issue(0, 0, 0, 1);
    do_issue(3, 0, 0, 0);
    do_issue(5, 0, 0, 0);
    chk("R8", blk_seq, 40, "younger refusal keeps older record");
    do_issue(1, 0, 0, 0);
    chk("R8", blk_seq, 20, "older refusal replaces record");
    blk_ack = 1; step(); idle();
    chk("R9", blk_handled, 1, "ack sets handled");
    blk_clear = 1; step(); idle();
    chk("R9", blk_valid, 0, "clear drops record");
    do_issue(2, 0, 0, 1);
    chk("R7", retry_pend, 0, "accept clears retry");

    // R6: uncached gating
    do_issue(2, 1, 1, 1);
    do_issue(0, 1, 0, 1);
    do_issue(0, 1, 1, 1);

    // R4: commit frees 10, 20, 30
    commit_valid = 1; commit_seq = 35; step(); idle();
    chk("R4", lq_count, 4, "commit frees older run");
    step();

    // R2: wrap the tail
    for (int i = 8; i <= 10; i++) begin
      alloc_valid = 1; alloc_seq = SEQ_W'(i * 10); alloc_sq_idx = SQI_W'(i);
      step();
    end
    idle();

    // R10 R11: squash above 55, with issue/commit/alloc during the walk
    squash_valid = 1; squash_seq = 55; step(); idle();
    for (int i = 0; i < 8; i++) begin
      issue_valid = 1; issue_idx = IDX_W'(3); commit_valid = 1; commit_seq = 999;
      alloc_valid = 1; alloc_seq = 500; squash_valid = 1; squash_seq = 0;
      if (!squash_busy) begin idle(); end
      step();
    end
    idle();
    chk("R10", lq_count, 2, "squash leaves 40 and 50");

    // R10: squash point above all entries frees nothing
    squash_valid = 1; squash_seq = 900; step(); idle();
    step(); step();
    chk("R10", lq_count, 2, "no-op squash");

    // R11: issue of a free slot
    do_issue(7, 0, 0, 0);
    chk("R11", retry_pend, 0, "free slot issue ignored");

    // R4: drain
    commit_valid = 1; commit_seq = 999; step(); idle();
    step();
    chk("R4", lq_count, 0, "full drain");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule